// File: doc/BRIEF.md
# Exception Entry Sequencer

This block walks a small 32-bit processor core through taking a trap, a non-maskable interrupt, a bus fault or an external interrupt. The core hands over a cause code, the vector for that cause, and a snapshot of its architectural state: program counter, status word, stack pointer, kernel stack pointer, exception base address and the pending delay-slot amount. The sequencer works out the saved return address, the new status word, the exception-status word and any stack swap. It presents all of these together in one commit cycle. After that it reads the handler address from the vector table and hands it back as the new program counter.

The request side is a valid/ready stream. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low for the whole sequence, so a request offered while the block is busy waits and is not lost. The vector-table port is a valid/ready request followed by a response-valid strobe. Once raised, `rd_valid` and `rd_addr` stay fixed until `rd_ready` is seen. The response cannot be back-pressured, and the block accepts it in any cycle once the request has been taken. `done` tells the core to drop its pending cause.

Top module: `exc_entry_seq`

## Requirements
- R1: `req_ready` is high exactly when `busy` is low. `busy` rises on the edge that accepts a request and falls on the edge that ends the `done` cycle. A request held high while busy is not accepted, and reset returns the block to idle with no outputs pulsed.
- R2: For cause 2'b00 (trap), 2'b10 (bus fault) and 2'b11 (interrupt), the vector used is `req_vector`. The commit cycle raises `erp_we` (not `nrp_we`) with the saved return address on `erp_val`.
- R3: For cause 2'b01 (NMI), the vector used is 0 whatever `req_vector` holds. The commit raises `nrp_we` (not `erp_we`) with the return address on `nrp_val`, and the new status word has bit 30 (the M flag) cleared.
- R4: `exs_val` at commit holds bits 7:0 of the vector used, in bits 15:8, with every other bit zero.
- R5: The saved return address is `cur_pc - cur_dslot`, computed modulo 2^32. The commit pulse also tells the core to clear its delay-slot flag.
- R6: If bit 8 (the U flag) of `cur_ccs` is set, the commit raises `sp_swap` with `usp_val = cur_sp` and `sp_val = cur_ksp`. Otherwise `sp_swap` stays low.
- R7: `ccs_val` at commit keeps bits 31:30 of the (M-adjusted) status word, holds its bits 19:0 in bits 29:10, and has bits 9:0 zero.
- R8: `commit` pulses for one cycle, two edges after acceptance, with every update present. `rd_valid` rises in the following cycle with `rd_addr = cur_ebp + 4 * vector`, and both hold until `rd_ready` is seen.
- R9: In the cycle `rd_rvalid` is high after the read was accepted, `pc_we` and `done` are high and `pc_val` equals `rd_rdata`. The block is idle in the next cycle.
- R10: `rd_rvalid` while no read is outstanding raises neither `pc_we` nor `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Entry request offered |
| req_ready | output | 1 | Block can take a request |
| req_cause | input | 2 | 00 trap, 01 NMI, 10 bus fault, 11 interrupt |
| req_vector | input | VEC_W | Vector supplied with the cause |
| cur_pc | input | XLEN | Program counter at entry |
| cur_ccs | input | XLEN | Status word at entry |
| cur_sp | input | XLEN | Stack pointer at entry |
| cur_ksp | input | XLEN | Kernel stack pointer value |
| cur_ebp | input | XLEN | Vector table base address |
| cur_dslot | input | DS_W | Pending delay-slot amount in bytes |
| busy | output | 1 | Sequence in progress |
| commit | output | 1 | One-cycle strobe: write all updates below |
| erp_we | output | 1 | Write exception return register |
| erp_val | output | XLEN | Exception return value |
| nrp_we | output | 1 | Write NMI return register |
| nrp_val | output | XLEN | NMI return value |
| ccs_val | output | XLEN | New status word |
| exs_val | output | XLEN | New exception-status word |
| sp_swap | output | 1 | Write both stack registers |
| sp_val | output | XLEN | New stack pointer |
| usp_val | output | XLEN | New user stack pointer |
| rd_valid | output | 1 | Vector-table read request |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | XLEN | Vector-table word address |
| rd_rvalid | input | 1 | Read data valid |
| rd_rdata | input | XLEN | Read data |
| pc_we | output | 1 | Write program counter |
| pc_val | output | XLEN | New program counter |
| done | output | 1 | Entry complete; clear pending cause |

## Verification
Take the accepting edge as edge 0. `busy` is sampled after edge 0 and `commit` is checked low after edge 1 and high after edge 2, along with every value it qualifies. `rd_valid` and `rd_addr` are checked after edge 3 and again after each cycle that `rd_ready` is held low. `pc_we`, `done` and `pc_val` are combinational on the response, so they are checked a moment after `rd_rvalid` is driven within the same cycle. The return to idle is checked after the following edge. All sampling happens at the falling clock edge, midway between the edges that move the design.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [1:0] {
    CAUSE_TRAP   = 2'b00,
    CAUSE_NMI    = 2'b01,
    CAUSE_BUSERR = 2'b10,
    CAUSE_IRQ    = 2'b11
  } cause_e;

  typedef enum logic [4:0] {
    ST_IDLE  = 5'b00001,
    ST_SAVE  = 5'b00010,
    ST_SHIFT = 5'b00100,
    ST_FETCH = 5'b01000,
    ST_WAIT  = 5'b10000
  } state_e;

  localparam int FLAG_U_BIT  = 8;
  localparam int CCS_SHIFT   = 10;
  localparam int CCS_KEEP    = 2;
endpackage

// File: rtl/exc_vec_route.sv
module exc_vec_route
  import exc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int VEC_W = 8,
  parameter int DS_W  = 2
) (
  input  cause_e             cause,
  input  logic [VEC_W-1:0]   vec_in,
  input  logic [XLEN-1:0]    pc,
  input  logic [DS_W-1:0]    dslot,
  output logic [VEC_W-1:0]   vec_out,
  output logic [XLEN-1:0]    ret_addr,
  output logic               is_nmi
);
  always_comb begin
    is_nmi   = (cause == CAUSE_NMI);
    vec_out  = is_nmi ? '0 : vec_in;
    ret_addr = pc - XLEN'(dslot);
  end
endmodule

// File: rtl/exc_status_calc.sv
module exc_status_calc
  import exc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int VEC_W = 8
) (
  input  logic [XLEN-1:0]  ccs_in,
  input  logic             clr_m,
  input  logic [VEC_W-1:0] vec,
  output logic [XLEN-1:0]  ccs_out,
  output logic [XLEN-1:0]  exs_out,
  output logic             user_mode
);
  localparam logic [XLEN-1:0] KEEP_MASK = {{CCS_KEEP{1'b1}}, {(XLEN-CCS_KEEP){1'b0}}};
  localparam logic [XLEN-1:0] M_MASK    = {2'b01, {(XLEN-2){1'b0}}};

  logic [XLEN-1:0] ccs_m;
  logic [7:0]      idx;

  always_comb begin
    ccs_m     = clr_m ? (ccs_in & ~M_MASK) : ccs_in;
    ccs_out   = (ccs_m & KEEP_MASK) | ((ccs_m << CCS_SHIFT) & ~KEEP_MASK);
    idx       = 8'(vec);
    exs_out   = {{(XLEN-16){1'b0}}, idx, 8'h00};
    user_mode = ccs_in[FLAG_U_BIT];
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int VEC_W = 8,
  parameter int DS_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_cause,
  input  logic [VEC_W-1:0] req_vector,
  input  logic [XLEN-1:0]  cur_pc,
  input  logic [XLEN-1:0]  cur_ccs,
  input  logic [XLEN-1:0]  cur_sp,
  input  logic [XLEN-1:0]  cur_ksp,
  input  logic [XLEN-1:0]  cur_ebp,
  input  logic [DS_W-1:0]  cur_dslot,
  output logic             busy,
  output logic             commit,
  output logic             erp_we,
  output logic [XLEN-1:0]  erp_val,
  output logic             nrp_we,
  output logic [XLEN-1:0]  nrp_val,
  output logic [XLEN-1:0]  ccs_val,
  output logic [XLEN-1:0]  exs_val,
  output logic             sp_swap,
  output logic [XLEN-1:0]  sp_val,
  output logic [XLEN-1:0]  usp_val,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [XLEN-1:0]  rd_addr,
  input  logic             rd_rvalid,
  input  logic [XLEN-1:0]  rd_rdata,
  output logic             pc_we,
  output logic [XLEN-1:0]  pc_val,
  output logic             done
);
  state_e state, nxt;

  cause_e           cause_q;
  logic [VEC_W-1:0] vin_q, vec_q;
  logic [XLEN-1:0]  pc_q, ccs_q, sp_q, ksp_q, ebp_q;
  logic [DS_W-1:0]  ds_q;
  logic [XLEN-1:0]  ret_q, exs_q, ccs_new_q, sp_new_q, usp_new_q, addr_q;
  logic             nmi_q, swap_q, commit_q;

  logic [VEC_W-1:0] vec_c;
  logic [XLEN-1:0]  ret_c, ccs_c, exs_c;
  logic             nmi_c, user_c;

  exc_vec_route #(.XLEN(XLEN), .VEC_W(VEC_W), .DS_W(DS_W)) u_route (
    .cause    (cause_q),
    .vec_in   (vin_q),
    .pc       (pc_q),
    .dslot    (ds_q),
    .vec_out  (vec_c),
    .ret_addr (ret_c),
    .is_nmi   (nmi_c)
  );

  exc_status_calc #(.XLEN(XLEN), .VEC_W(VEC_W)) u_status (
    .ccs_in    (ccs_q),
    .clr_m     (nmi_q),
    .vec       (vec_q),
    .ccs_out   (ccs_c),
    .exs_out   (exs_c),
    .user_mode (user_c)
  );

  assign req_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign rd_valid  = (state == ST_FETCH) && !commit_q;
  assign rd_addr   = addr_q;
  assign pc_we     = (state == ST_WAIT) && rd_rvalid;
  assign done      = pc_we;
  assign pc_val    = rd_rdata;

  assign commit  = commit_q;
  assign erp_we  = commit_q && !nmi_q;
  assign nrp_we  = commit_q && nmi_q;
  assign erp_val = ret_q;
  assign nrp_val = ret_q;
  assign ccs_val = ccs_new_q;
  assign exs_val = exs_q;
  assign sp_swap = commit_q && swap_q;
  assign sp_val  = sp_new_q;
  assign usp_val = usp_new_q;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  if (req_valid) nxt = ST_SAVE;
      ST_SAVE:  nxt = ST_SHIFT;
      ST_SHIFT: nxt = ST_FETCH;
      ST_FETCH: if (rd_valid && rd_ready) nxt = ST_WAIT;
      ST_WAIT:  if (rd_rvalid) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cause_q   <= CAUSE_TRAP;
      vin_q     <= '0;
      vec_q     <= '0;
      pc_q      <= '0;
      ccs_q     <= '0;
      sp_q      <= '0;
      ksp_q     <= '0;
      ebp_q     <= '0;
      ds_q      <= '0;
      ret_q     <= '0;
      exs_q     <= '0;
      ccs_new_q <= '0;
      sp_new_q  <= '0;
      usp_new_q <= '0;
      addr_q    <= '0;
      nmi_q     <= 1'b0;
      swap_q    <= 1'b0;
      commit_q  <= 1'b0;
    end else begin
      state    <= nxt;
      commit_q <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          cause_q <= cause_e'(req_cause);
          vin_q   <= req_vector;
          pc_q    <= cur_pc;
          ccs_q   <= cur_ccs;
          sp_q    <= cur_sp;
          ksp_q   <= cur_ksp;
          ebp_q   <= cur_ebp;
          ds_q    <= cur_dslot;
        end
        ST_SAVE: begin
          ret_q <= ret_c;
          vec_q <= vec_c;
          nmi_q <= nmi_c;
        end
        ST_SHIFT: begin
          ccs_new_q <= ccs_c;
          exs_q     <= exs_c;
          swap_q    <= user_c;
          usp_new_q <= sp_q;
          sp_new_q  <= user_c ? ksp_q : sp_q;
          addr_q    <= ebp_q + (XLEN'(vec_q) << 2);
          commit_q  <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            busy,
  input logic            commit,
  input logic            erp_we,
  input logic            nrp_we,
  input logic [XLEN-1:0] ccs_val,
  input logic [XLEN-1:0] exs_val,
  input logic            rd_valid,
  input logic            rd_ready,
  input logic [XLEN-1:0] rd_addr,
  input logic            rd_rvalid,
  input logic [XLEN-1:0] rd_rdata,
  input logic            pc_we,
  input logic [XLEN-1:0] pc_val,
  input logic            done
);
  AST_READY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !req_ready); // R1
  AST_ONE_RETURN_REG: assert property (@(posedge clk) disable iff (!rst_n) commit |-> $onehot({erp_we, nrp_we})); // R2
  AST_EXS_FIELD: assert property (@(posedge clk) disable iff (!rst_n) commit |-> (exs_val[XLEN-1:16] == '0 && exs_val[7:0] == 8'h00)); // R4
  AST_CCS_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) commit |-> ccs_val[9:0] == 10'h000); // R7
  AST_COMMIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n) $rose(rd_valid) |-> $past(commit)); // R8
  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n) (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr))); // R8
  AST_PC_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n) pc_we |-> (rd_rvalid && pc_val == rd_rdata && done)); // R9
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy); // R9
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .busy      (busy),
  .commit    (commit),
  .erp_we    (erp_we),
  .nrp_we    (nrp_we),
  .ccs_val   (ccs_val),
  .exs_val   (exs_val),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_addr   (rd_addr),
  .rd_rvalid (rd_rvalid),
  .rd_rdata  (rd_rdata),
  .pc_we     (pc_we),
  .pc_val    (pc_val),
  .done      (done)
);

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
  localparam int XLEN  = 32;
  localparam int VEC_W = 8;
  localparam int DS_W  = 2;

  typedef struct packed {
    logic [1:0]  cause;
    logic [7:0]  vec;
    logic [31:0] pc;
    logic [31:0] ccs;
    logic [31:0] sp;
    logic [31:0] ksp;
    logic [31:0] ebp;
    logic [1:0]  ds;
    logic [3:0]  rdy_dly;
    logic [3:0]  rsp_dly;
    logic        hold;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t TABLE [NV] = '{
    '{2'b00, 8'h21, 32'h0000_1004, 32'h8000_0120, 32'h0000_7FF0, 32'h0000_9000, 32'h0001_0000, 2'd0, 4'd0, 4'd0, 1'b0},
    '{2'b01, 8'h55, 32'h0000_2000, 32'h4000_0105, 32'h1111_0000, 32'h2222_0000, 32'h0002_0000, 2'd2, 4'd2, 4'd1, 1'b1},
    '{2'b10, 8'h7E, 32'h3000_0010, 32'hC00F_FEFF, 32'h3333_0000, 32'h4444_0000, 32'h0003_0000, 2'd0, 4'd1, 4'd3, 1'b0},
    '{2'b11, 8'hFF, 32'h4000_0000, 32'h0000_0100, 32'h5555_0000, 32'h6666_0000, 32'hFFFF_FF00, 2'd3, 4'd0, 4'd0, 1'b0},
    '{2'b00, 8'h00, 32'h0000_0000, 32'h0000_0000, 32'h7777_0000, 32'h8888_0000, 32'h0004_0000, 2'd1, 4'd3, 4'd2, 1'b1},
    '{2'b11, 8'h80, 32'hABCD_0000, 32'hFFFF_FFFF, 32'h9999_0000, 32'hAAAA_0000, 32'h0005_0000, 2'd0, 4'd0, 4'd1, 1'b0}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [1:0]       req_cause = '0;
  logic [VEC_W-1:0] req_vector = '0;
  logic [XLEN-1:0]  cur_pc = '0, cur_ccs = '0, cur_sp = '0, cur_ksp = '0, cur_ebp = '0;
  logic [DS_W-1:0]  cur_dslot = '0;
  logic             busy, commit, erp_we, nrp_we, sp_swap, rd_valid, pc_we, done;
  logic [XLEN-1:0]  erp_val, nrp_val, ccs_val, exs_val, sp_val, usp_val, rd_addr, pc_val;
  logic             rd_ready = 1'b0;
  logic             rd_rvalid = 1'b0;
  logic [XLEN-1:0]  rd_rdata = '0;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  exc_entry_seq #(.XLEN(XLEN), .VEC_W(VEC_W), .DS_W(DS_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cause(req_cause), .req_vector(req_vector), .cur_pc(cur_pc), .cur_ccs(cur_ccs),
    .cur_sp(cur_sp), .cur_ksp(cur_ksp), .cur_ebp(cur_ebp), .cur_dslot(cur_dslot),
    .busy(busy), .commit(commit), .erp_we(erp_we), .erp_val(erp_val), .nrp_we(nrp_we),
    .nrp_val(nrp_val), .ccs_val(ccs_val), .exs_val(exs_val), .sp_swap(sp_swap),
    .sp_val(sp_val), .usp_val(usp_val), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata), .pc_we(pc_we),
    .pc_val(pc_val), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_ccs(input vec_t v);
    logic [31:0] m;
    m = (v.cause == 2'b01) ? (v.ccs & ~32'h4000_0000) : v.ccs;
    return (m & 32'hC000_0000) | ((m << 10) & 32'h3FFF_FC00);
  endfunction

  task automatic run_entry(input vec_t v, input int idx);
    logic [7:0]  ev;
    logic [31:0] ret, addr, data;
    logic        nmi, usr;
    nmi  = (v.cause == 2'b01);
    ev   = nmi ? 8'h00 : v.vec;
    ret  = v.pc - {30'd0, v.ds};
    addr = v.ebp + {22'd0, ev, 2'b00};
    data = addr ^ 32'h5A5A_0F0F ^ idx;
    usr  = v.ccs[8];

    @(negedge clk);
    req_cause = v.cause; req_vector = v.vec; cur_pc = v.pc; cur_ccs = v.ccs;
    cur_sp = v.sp; cur_ksp = v.ksp; cur_ebp = v.ebp; cur_dslot = v.ds;
    req_valid = 1'b1;
    #1 chk("R1 ready when idle", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    chk("R1 busy after accept", {31'd0, busy}, 32'd1);
    chk("R1 ready low when busy", {31'd0, req_ready}, 32'd0);
    if (!v.hold) req_valid = 1'b0;
    else begin req_cause = 2'b11; req_vector = 8'h3C; end
    @(negedge clk);
    chk("R8 no commit at edge 1", {31'd0, commit}, 32'd0);
    @(negedge clk);
    chk("R8 commit at edge 2", {31'd0, commit}, 32'd1);
    chk("R8 no read during commit", {31'd0, rd_valid}, 32'd0);
    chk("R2 R3 erp_we", {31'd0, erp_we}, {31'd0, !nmi});
    chk("R3 nrp_we", {31'd0, nrp_we}, {31'd0, nmi});
    if (nmi) chk("R3 R5 nrp_val", nrp_val, ret);
    else     chk("R2 R5 erp_val", erp_val, ret);
    chk("R7 R3 ccs_val", ccs_val, exp_ccs(v));
    chk("R4 exs_val", exs_val, {16'd0, ev, 8'd0});
    chk("R6 sp_swap", {31'd0, sp_swap}, {31'd0, usr});
    if (usr) begin
      chk("R6 usp_val", usp_val, v.sp);
      chk("R6 sp_val", sp_val, v.ksp);
    end
    @(negedge clk);
    chk("R8 read issued", {31'd0, rd_valid}, 32'd1);
    chk("R8 read address", rd_addr, addr);
    for (int i = 0; i < int'(v.rdy_dly); i++) begin
      @(negedge clk);
      chk("R8 read held", {31'd0, rd_valid}, 32'd1);
      chk("R8 address held", rd_addr, addr);
    end
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
    chk("R8 read dropped after accept", {31'd0, rd_valid}, 32'd0);
    for (int i = 0; i < int'(v.rsp_dly); i++) begin
      chk("R9 no done before data", {31'd0, done}, 32'd0);
      @(negedge clk);
    end
    rd_rvalid = 1'b1; rd_rdata = data;
    #1;
    chk("R9 pc_we", {31'd0, pc_we}, 32'd1);
    chk("R9 done", {31'd0, done}, 32'd1);
    chk("R9 pc_val", pc_val, data);
    @(negedge clk);
    rd_rvalid = 1'b0;
    chk("R1 R9 idle after done", {31'd0, busy}, 32'd0);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset busy", {31'd0, busy}, 32'd0);
    chk("R1 reset ready", {31'd0, req_ready}, 32'd1);
    chk("R1 reset commit", {31'd0, commit}, 32'd0);
    chk("R1 reset rd_valid", {31'd0, rd_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {31'd0, busy | pc_we | done}, 32'd0);

    for (int n = 0; n < NV; n++) run_entry(TABLE[n], n);

    // R10: response strobe with no read outstanding
    @(negedge clk);
    rd_rvalid = 1'b1; rd_rdata = 32'hDEAD_BEEF;
    #1;
    chk("R10 stray data no pc_we", {31'd0, pc_we}, 32'd0);
    chk("R10 stray data no done", {31'd0, done}, 32'd0);
    @(negedge clk);
    rd_rvalid = 1'b0;
    chk("R10 still idle", {31'd0, busy}, 32'd0);

    // R1: reset in the middle of a sequence
    req_cause = 2'b00; req_vector = 8'h11; cur_ccs = 32'h0000_0100;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 busy before abort", {31'd0, busy}, 32'd1);
    rst_n = 1'b0;
    #1;
    chk("R1 reset aborts busy", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk("R1 no commit under reset", {31'd0, commit}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 no commit after abort", {31'd0, commit}, 32'd0);
    chk("R1 no read after abort", {31'd0, rd_valid}, 32'd0);

    run_entry(TABLE[0], 7);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule